// File: doc/BRIEF.md
# Adjacent-State Predictive Switching Selector

This block picks, once per control period, the switch word for a three-level non-inverting buck-boost power stage run under finite-control-set predictive control. It holds the state now applied to the four half-bridge controls Q1..Q4. It lists the states the stage may move to next: the present state and every state one switch toggle away. It then offers these one at a time to an external cost evaluator and keeps the candidate with the lowest returned cost. The winning state goes out as a 4-bit switch word and as eight complementary gate drives.

Eleven of the sixteen Q1..Q4 combinations are used. Seven are the main buck and boost states, with M1 shared by both groups. The other four are balancing states whose codes are parameters. When the evaluator side signals capacitor imbalance and the present state has a far partner (M2 with M4, M5 with M7), that partner is added to the list even though it is two toggles away. If the partner wins, the bridge state M1 is applied first, and the partner follows on the next control period without a new evaluation. Each applied state therefore differs from the one before in exactly one switch.

The evaluator handshake is simple. While `cand_valid` is high, `cand_idx` names the state under test. The evaluator answers with `cost`, `cost_oc` and `cost_valid`, either in the same clock or after a stall. A candidate flagged for predicted overcurrent is dropped.

Top module: `sws_selector`

## Requirements
- R1: After reset `sw_state` is M1 (4'b1010), no deferred target is pending, and `done` and `cand_valid` are low.
- R2: State indices are 0..6 for M1..M7 and 7..10 for the balancing states B1..B4. `sw_state[3]` is Q1 and `sw_state[0]` is Q4. The main codes are M1=1010, M2=1110, M3=0110, M4=0010, M5=1011, M6=1001 and M7=1000. The default balancing codes are B1=1111, B2=1100, B3=0111 and B4=0100.
- R3: A poll first offers the present state. It then offers every state whose code differs from the present code in exactly one bit, in ascending index order. From M1 the order is M1, M2, M4, M5, M7.
- R4: If `imbal` is high in the clock that accepts `cycle_start`, and the present state is M2, M4, M5 or M7, its partner (M2 with M4, M5 with M7) is appended as the last candidate. At most six candidates are polled.
- R5: The running best starts at the all-ones cost. A candidate replaces it only when its cost is strictly lower, so among equal costs the earliest candidate wins, and a cost of all ones never wins.
- R6: A candidate whose answer has `cost_oc` high is never chosen. If no candidate qualifies, the present state is held.
- R7: If the appended partner wins, M1 is applied and the partner is kept pending. The next accepted `cycle_start` applies the partner one clock later, with no candidate polled. `imbal` has no effect on that step.
- R8: Consecutive values of `sw_state` differ in exactly one bit. The codes 0000, 0001, 0011, 0101 and 1101 never appear.
- R9: For each Qi, held in `sw_state` bit b, `gate[2b+1]` equals that bit and `gate[2b]` is its complement.
- R10: `done` is a one-clock pulse. It goes high one clock after the edge that accepts the last cost, and `sw_state` changes in the same clock. When every candidate is answered at once, `done` follows the accepting `cycle_start` edge by N clocks. A `cycle_start` that arrives while a poll is running is ignored.
- R11: While `cand_valid` is high and `cost_valid` is low, `cand_valid` and `cand_idx` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cycle_start | input | 1 | One-clock request to decide the next control period |
| imbal | input | 1 | Capacitor imbalance flag, sampled with cycle_start |
| cand_valid | output | 1 | Candidate offered to the evaluator |
| cand_idx | output | 4 | Index of the offered candidate |
| cost | input | COST_W | Cost of the offered candidate |
| cost_oc | input | 1 | Predicted overcurrent for the offered candidate |
| cost_valid | input | 1 | Evaluator answer present this clock |
| sw_state | output | 4 | Applied Q1..Q4 word |
| gate | output | 8 | Complementary gate drives, two per switch bit |
| done | output | 1 | Decision pulse |

## Verification
The bench builds the block with a 16-bit cost and the default balancing codes. With these values the present state and its one-bit neighbours give candidate lists of three to five entries, and six when a partner is appended, so every list length is exercised. Costs are mostly drawn from 0..15, which makes ties frequent, with some all-ones costs that test the strict comparison. Random evaluator stalls exercise the handshake hold, and random imbalance flags let the random walk pass through deferred bridge transitions in both the buck and boost groups.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int NUM_ST   = 11;
  localparam int IDX_W    = 4;
  localparam int CODE_W   = 4;
  localparam int LIST_MAX = 6;
  localparam int CNT_W    = 3;
  localparam int VEC_W    = NUM_ST * CODE_W;

  typedef logic [IDX_W-1:0] st_idx_t;
  typedef enum logic [0:0] {PH_IDLE, PH_POLL} phase_e;

  localparam st_idx_t IDX_BRIDGE = 4'd0;

  // Main state codes, Q1 in the most significant bit.
  function automatic logic [CODE_W-1:0] main_code(int k);
    case (k)
      0:       main_code = 4'b1010;
      1:       main_code = 4'b1110;
      2:       main_code = 4'b0110;
      3:       main_code = 4'b0010;
      4:       main_code = 4'b1011;
      5:       main_code = 4'b1001;
      default: main_code = 4'b1000;
    endcase
  endfunction

  function automatic logic has_partner(st_idx_t s);
    has_partner = (s == 4'd1) || (s == 4'd3) || (s == 4'd4) || (s == 4'd6);
  endfunction

  function automatic st_idx_t partner_of(st_idx_t s);
    case (s)
      4'd1:    partner_of = 4'd3;
      4'd3:    partner_of = 4'd1;
      4'd4:    partner_of = 4'd6;
      4'd6:    partner_of = 4'd4;
      default: partner_of = s;
    endcase
  endfunction

  // Number of states whose code lies one toggle away from state k.
  function automatic int nb_count(logic [VEC_W-1:0] v, int k);
    int c;
    c = 0;
    for (int j = 0; j < NUM_ST; j++)
      if ($countones(v[j*CODE_W +: CODE_W] ^ v[k*CODE_W +: CODE_W]) == 1) c++;
    nb_count = c;
  endfunction
endpackage

// File: rtl/sws_cand_list.sv
module sws_cand_list
  import sws_pkg::*;
#(
  parameter logic [VEC_W-1:0] CODE_VEC = '0
) (
  input  st_idx_t                            cur_idx,
  input  logic                               imbal,
  output logic [LIST_MAX-1:0][IDX_W-1:0]     list,
  output logic [CNT_W-1:0]                   count,
  output logic                               forced
);
  logic [CODE_W-1:0] cur_code;
  logic [NUM_ST-1:0] adj;
  logic [CNT_W-1:0]  n;

  assign cur_code = CODE_VEC[cur_idx*CODE_W +: CODE_W];
  assign forced   = imbal && has_partner(cur_idx);

  for (genvar g = 0; g < NUM_ST; g++) begin : g_adj
    assign adj[g] = ($countones(cur_code ^ CODE_VEC[g*CODE_W +: CODE_W]) == 1);
  end

  // Present state first, single-toggle neighbours next, forced partner last.
  always_comb begin
    list    = '0;
    list[0] = cur_idx;
    n       = CNT_W'(1);
    for (int i = 0; i < NUM_ST; i++) begin
      if (adj[i]) begin
        list[n] = IDX_W'(i);
        n       = n + CNT_W'(1);
      end
    end
    if (forced) begin
      list[n] = partner_of(cur_idx);
      n       = n + CNT_W'(1);
    end
    count = n;
  end
endmodule

// File: rtl/sws_min_track.sv
module sws_min_track
  import sws_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [COST_W-1:0] cost,
  input  logic              oc,
  input  st_idx_t           idx,
  output st_idx_t           best_idx_nxt,
  output logic              found_nxt
);
  localparam logic [COST_W-1:0] COST_TOP = '1;

  logic [COST_W-1:0] best_cost_q, best_cost_d;
  st_idx_t           best_idx_q;
  logic              found_q;
  logic              better;

  assign better = take && !oc && (cost < best_cost_q);

  always_comb begin
    best_cost_d  = best_cost_q;
    best_idx_nxt = best_idx_q;
    found_nxt    = found_q;
    if (clear) begin
      best_cost_d  = COST_TOP;
      best_idx_nxt = '0;
      found_nxt    = 1'b0;
    end else if (better) begin
      best_cost_d  = cost;
      best_idx_nxt = idx;
      found_nxt    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_cost_q <= COST_TOP;
      best_idx_q  <= '0;
      found_q     <= 1'b0;
    end else if (clear || better) begin
      best_cost_q <= best_cost_d;
      best_idx_q  <= best_idx_nxt;
      found_q     <= found_nxt;
    end
  end
endmodule

// File: rtl/sws_gate_map.sv
module sws_gate_map
  import sws_pkg::*;
(
  input  logic [CODE_W-1:0]   sw,
  output logic [2*CODE_W-1:0] gate
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_leg
    assign gate[2*i+1] = sw[i];
    assign gate[2*i]   = ~sw[i];
  end
endmodule

// File: rtl/sws_selector.sv
module sws_selector
  import sws_pkg::*;
#(
  parameter int          COST_W  = 16,
  parameter logic [3:0]  B1_CODE = 4'b1111,
  parameter logic [3:0]  B2_CODE = 4'b1100,
  parameter logic [3:0]  B3_CODE = 4'b0111,
  parameter logic [3:0]  B4_CODE = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              imbal,
  output logic              cand_valid,
  output logic [3:0]        cand_idx,
  input  logic [COST_W-1:0] cost,
  input  logic              cost_oc,
  input  logic              cost_valid,
  output logic [3:0]        sw_state,
  output logic [7:0]        gate,
  output logic              done
);
  localparam logic [VEC_W-1:0] CODE_VEC = {B4_CODE, B3_CODE, B2_CODE, B1_CODE,
                                           main_code(6), main_code(5), main_code(4),
                                           main_code(3), main_code(2), main_code(1),
                                           main_code(0)};

  // Elaboration checks on the balancing codes.
  for (genvar a = 0; a < NUM_ST; a++) begin : g_chk_a
    for (genvar b = a + 1; b < NUM_ST; b++) begin : g_chk_b
      if (CODE_VEC[a*CODE_W +: CODE_W] == CODE_VEC[b*CODE_W +: CODE_W]) begin : g_dup
        $error("sws_selector: two states share one switch code");
      end
    end
  end
  for (genvar m = 7; m < NUM_ST; m++) begin : g_chk_nb
    if (nb_count(CODE_VEC, m) == 0) begin : g_iso
      $error("sws_selector: balancing code has no single-toggle neighbour");
    end
  end

  phase_e                        phase_q, phase_d;
  st_idx_t                       cur_q, cur_d;
  st_idx_t                       pend_q, pend_d;
  logic                          pend_vld_q, pend_vld_d;
  logic [LIST_MAX-1:0][IDX_W-1:0] list_q, list_w;
  logic [CNT_W-1:0]              cnt_q, cnt_w;
  logic [CNT_W-1:0]              ptr_q, ptr_d;
  logic                          forced_q, forced_w;
  logic                          done_q, done_d;

  logic    start_acc, load_en, take, last;
  st_idx_t best_idx_nxt;
  logic    found_nxt;

  sws_cand_list #(.CODE_VEC(CODE_VEC)) u_list (
    .cur_idx (cur_q),
    .imbal   (imbal),
    .list    (list_w),
    .count   (cnt_w),
    .forced  (forced_w)
  );

  assign start_acc = (phase_q == PH_IDLE) && cycle_start;
  assign load_en   = start_acc && !pend_vld_q;
  assign take      = (phase_q == PH_POLL) && cost_valid;
  assign last      = take && (ptr_q == cnt_q - CNT_W'(1));

  sws_min_track #(.COST_W(COST_W)) u_min (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (load_en),
    .take         (take),
    .cost         (cost),
    .oc           (cost_oc),
    .idx          (list_q[ptr_q]),
    .best_idx_nxt (best_idx_nxt),
    .found_nxt    (found_nxt)
  );

  always_comb begin
    phase_d    = phase_q;
    cur_d      = cur_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    ptr_d      = ptr_q;
    done_d     = 1'b0;
    if (start_acc) begin
      if (pend_vld_q) begin
        cur_d      = pend_q;
        pend_vld_d = 1'b0;
        done_d     = 1'b1;
      end else begin
        phase_d = PH_POLL;
        ptr_d   = '0;
      end
    end
    if (take) begin
      ptr_d = ptr_q + CNT_W'(1);
      if (last) begin
        phase_d = PH_IDLE;
        ptr_d   = '0;
        done_d  = 1'b1;
        if (found_nxt) begin
          if (forced_q && (best_idx_nxt == partner_of(cur_q))) begin
            cur_d      = IDX_BRIDGE;
            pend_d     = best_idx_nxt;
            pend_vld_d = 1'b1;
          end else begin
            cur_d = best_idx_nxt;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cur_q      <= IDX_BRIDGE;
      pend_q     <= IDX_BRIDGE;
      pend_vld_q <= 1'b0;
      ptr_q      <= '0;
      done_q     <= 1'b0;
      list_q     <= '0;
      cnt_q      <= CNT_W'(1);
      forced_q   <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cur_q      <= cur_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      ptr_q      <= ptr_d;
      done_q     <= done_d;
      if (load_en) begin
        list_q   <= list_w;
        cnt_q    <= cnt_w;
        forced_q <= forced_w;
      end
    end
  end

  assign cand_valid = (phase_q == PH_POLL);
  assign cand_idx   = list_q[ptr_q];
  assign sw_state   = CODE_VEC[cur_q*CODE_W +: CODE_W];
  assign done       = done_q;

  sws_gate_map u_gate (
    .sw   (sw_state),
    .gate (gate)
  );
endmodule

// File: rtl/sws_selector_chk.sv
module sws_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cand_valid,
  input logic       cost_valid,
  input logic [3:0] cand_idx,
  input logic [3:0] sw_state,
  input logic       done
);
  logic [2:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hs_cnt <= '0;
    else if (done)                    hs_cnt <= '0;
    else if (cand_valid && cost_valid) hs_cnt <= hs_cnt + 3'd1;
  end

  p_single_hop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_state) |-> ($countones(sw_state ^ $past(sw_state)) == 1));

  p_change_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_state) |-> done);

  p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cost_valid) |=> (cand_valid && $stable(cand_idx)));

  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (hs_cnt < 3'd6));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_idx < 4'd11));

  p_no_poll_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid);
endmodule

bind sws_selector sws_selector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .cost_valid (cost_valid),
  .cand_idx   (cand_idx),
  .sw_state   (sw_state),
  .done       (done)
);

// File: tb/sws_selector_tb.sv
`timescale 1ns/1ps
module sws_selector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cycle_start, imbal, cost_oc, cost_valid;
  logic [15:0] cost;
  logic        cand_valid, done;
  logic [3:0]  cand_idx, sw_state;
  logic [7:0]  gate;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  int m_cur = 0, m_pend = -1;
  int exp_list[6];
  int exp_n;
  logic [15:0] cost_plan[6];
  bit          oc_plan[6];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sws_selector u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .imbal(imbal),
    .cand_valid(cand_valid), .cand_idx(cand_idx), .cost(cost), .cost_oc(cost_oc),
    .cost_valid(cost_valid), .sw_state(sw_state), .gate(gate), .done(done)
  );

  function automatic logic [3:0] mcode(int k);
    case (k)
      0: mcode = 4'b1010;  1: mcode = 4'b1110;  2: mcode = 4'b0110;
      3: mcode = 4'b0010;  4: mcode = 4'b1011;  5: mcode = 4'b1001;
      6: mcode = 4'b1000;  7: mcode = 4'b1111;  8: mcode = 4'b1100;
      9: mcode = 4'b0111;  default: mcode = 4'b0100;
    endcase
  endfunction

  function automatic int mpartner(int k);
    case (k)
      1: mpartner = 3;  3: mpartner = 1;
      4: mpartner = 6;  6: mpartner = 4;
      default: mpartner = -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_gate(logic [3:0] c);
    logic [7:0] g;
    for (int i = 0; i < 4; i++) begin
      g[2*i+1] = c[i];
      g[2*i]   = ~c[i];
    end
    exp_gate = g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic plan(input logic [15:0] c0, c1, c2, c3, c4, c5, input bit [5:0] ocm);
    cost_plan[0] = c0; cost_plan[1] = c1; cost_plan[2] = c2;
    cost_plan[3] = c3; cost_plan[4] = c4; cost_plan[5] = c5;
    for (int i = 0; i < 6; i++) oc_plan[i] = ocm[i];
  endtask

  task automatic resync();
    cost_valid = 1'b1; cost_oc = 1'b1; cost = '1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!cand_valid) break;
    end
    cost_valid = 1'b0;
    for (int k = 0; k < 11; k++) if (mcode(k) == sw_state) m_cur = k;
    m_pend = -1;
    @(negedge clk);
  endtask

  task automatic run_cycle(input bit imb, input bit stall_ok, input bit poke, input string req);
    int n, stalls, t0, win, part, exp_st;
    bit forced, bad;
    logic [15:0] best;
    if (m_pend >= 0) begin
      @(negedge clk); cycle_start = 1'b1; imbal = imb;
      @(negedge clk); cycle_start = 1'b0; imbal = 1'b0;
      chk(done === 1'b1, "R7", "done after deferred start", 32'(done), 1);
      chk(cand_valid === 1'b0, "R7", "no poll on deferred step", 32'(cand_valid), 0);
      chk(sw_state === mcode(m_pend), "R7", "deferred target applied", 32'(sw_state), 32'(mcode(m_pend)));
      m_cur = m_pend; m_pend = -1;
      @(negedge clk);
      chk(done === 1'b0, "R10", "done lasts one clock", 32'(done), 0);
      return;
    end
    exp_list[0] = m_cur; exp_n = 1;
    for (int k = 0; k < 11; k++)
      if ($countones(mcode(k) ^ mcode(m_cur)) == 1) begin exp_list[exp_n] = k; exp_n++; end
    part   = mpartner(m_cur);
    forced = imb && (part >= 0);
    if (forced) begin exp_list[exp_n] = part; exp_n++; end
    best = '1; win = -1;
    for (int j = 0; j < exp_n; j++)
      if (!oc_plan[j] && cost_plan[j] < best) begin best = cost_plan[j]; win = exp_list[j]; end

    @(negedge clk); cycle_start = 1'b1; imbal = imb;
    @(negedge clk); cycle_start = 1'b0; imbal = 1'b0;
    t0 = cyc; n = 0; stalls = 0; bad = 0;
    while (n < exp_n && !bad) begin
      chk(cand_valid === 1'b1 && cand_idx === 4'(exp_list[n]),
          (forced && n == exp_n - 1) ? "R4" : "R3", "candidate order",
          {27'(cand_valid), cand_idx}, {27'd1, 4'(exp_list[n])});
      if (!(cand_valid === 1'b1 && cand_idx === 4'(exp_list[n]))) begin
        bad = 1;
      end else if (stall_ok && ($urandom % 4 == 0) && stalls < 20) begin
        cost_valid = 1'b0; stalls++;
        @(negedge clk);
      end else begin
        cost_valid = 1'b1; cost = cost_plan[n]; cost_oc = oc_plan[n];
        if (poke && n == 1) cycle_start = 1'b1;
        @(negedge clk);
        cost_valid = 1'b0; cycle_start = 1'b0;
        n++;
      end
    end
    if (bad) begin resync(); return; end
    chk(done === 1'b1, "R10", "done after last cost", 32'(done), 1);
    chk(cyc - t0 == exp_n + stalls, "R10", "decision latency", 32'(cyc - t0), 32'(exp_n + stalls));
    if (win < 0) exp_st = m_cur;
    else if (forced && win == part) begin exp_st = 0; m_pend = part; end
    else exp_st = win;
    chk(sw_state === mcode(exp_st), req, "chosen state", 32'(sw_state), 32'(mcode(exp_st)));
    chk(gate === exp_gate(mcode(exp_st)), "R9", "gate drive", 32'(gate), 32'(exp_gate(mcode(exp_st))));
    m_cur = exp_st;
    @(negedge clk);
    chk(done === 1'b0, "R10", "done lasts one clock", 32'(done), 0);
    if (poke) chk(cand_valid === 1'b0, "R10", "start during poll ignored", 32'(cand_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; cycle_start = 1'b0; imbal = 1'b0;
    cost = '0; cost_oc = 1'b0; cost_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw_state === 4'b1010, "R1", "reset state", 32'(sw_state), 32'hA);
    chk(done === 1'b0 && cand_valid === 1'b0, "R1", "reset strobes", {30'd0, done, cand_valid}, 0);
    chk(gate === exp_gate(4'b1010), "R9", "reset gate", 32'(gate), 32'(exp_gate(4'b1010)));

    // From M1 (list M1,M2,M4,M5,M7): M2 wins.
    plan(9, 2, 9, 9, 9, 0, 6'b000000); run_cycle(0, 0, 0, "R3");
    // From M2 with imbalance: M4 appended and wins -> bridge M1, then M4.
    plan(9, 9, 9, 9, 9, 1, 6'b000000); run_cycle(1, 0, 0, "R7");
    run_cycle(1, 0, 0, "R7");
    // From M4 every answer overcurrent: hold.
    plan(1, 1, 1, 0, 0, 0, 6'b000111); run_cycle(0, 0, 0, "R6");
    // All-ones costs never win: hold.
    plan(16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 6'b000000); run_cycle(0, 0, 0, "R5");
    // Tie between M1 and M3: earliest (M1) wins.
    plan(9, 4, 4, 0, 0, 0, 6'b000000); run_cycle(0, 0, 0, "R5");
    // Start pulse during poll is ignored; stay at M1.
    plan(1, 5, 5, 5, 5, 0, 6'b000000); run_cycle(0, 0, 1, "R10");
    // Lowest cost flagged overcurrent: next best (M7) wins.
    plan(9, 9, 9, 1, 5, 0, 6'b001000); run_cycle(0, 0, 0, "R6");
    // From M7 with imbalance: M5 appended and wins -> M1 then M5.
    plan(9, 9, 9, 9, 0, 0, 6'b000000); run_cycle(1, 1, 0, "R7");
    run_cycle(0, 0, 0, "R7");

    for (int it = 0; it < 300; it++) begin
      for (int j = 0; j < 6; j++) begin
        cost_plan[j] = ($urandom % 12 == 0) ? 16'hFFFF : 16'($urandom % 16);
        oc_plan[j]   = ($urandom % 5 == 0);
      end
      run_cycle(($urandom % 3 == 0), 1, ($urandom % 10 == 0), "R5");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule